// File: doc/BRIEF.md
# USB Function Node Power State Controller

This block keeps track of which power state a full-speed USB function node is in: held in reset, running normally, suspended, or waking up. It listens to bus-event detections from the line logic (a USB reset, resume signalling and raw bus activity) and to firmware commands. It also takes a local wake-up request from the product. From these it drives the current state code and two hold-off controls for the rest of the node.

Two idle timers run on a microsecond tick taken from the system clock. The first raises a suspend-detected flag after a short stretch of silence on the upstream port. The second raises a longer idle flag, and only after that flag is set may the node start a remote wake-up.

Hardware detection alone never moves the node into suspend or back into operation. Firmware must confirm each of those moves in a cycle where the matching detection flag is already set. Every detection flag stays set until firmware clears it.

Top module: `usb_node_pwr_fsm`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `node_state` is 2'b00. All four flags are 0, `ep_disable` is 1 and `port_hold` is 1.
- R2: The state moves from operational (2'b10) to suspend (2'b11) on a clock edge only when `suspend_flag` and `fw_set_suspend` are both high before that edge.
- R3: The state moves from resume (2'b01) to operational only when `resume_flag` and `fw_set_oper` are both high before the edge. `fw_set_oper` without `resume_flag` leaves the state at resume.
- R4: From suspend, the state moves to resume on an edge where `resume_flag` is set, or where `local_wake` is high and `idle5_flag` is already set. `local_wake` has no effect while `idle5_flag` is 0.
- R5: From reset, the state moves to operational on an edge where `fw_set_oper` is high.
- R6: On an edge where `usb_rst_flag` and `fw_set_reset` are both high, the state becomes reset from any state, and this overrides every other transition. `fw_set_reset` alone has no effect.
- R7: An idle counter counts one tick per `TICK_DIV` clocks and restarts whenever `bus_active` is high. After an edge with `bus_active` high, `suspend_flag` becomes 1 on the idle edge numbered SUSP_US*TICK_DIV+1.
- R8: By the same counting, `idle5_flag` becomes 1 on the idle edge numbered WAKE_US*TICK_DIV+1.
- R9: A cycle with `bus_active` high restarts both timers from zero. It leaves flags that are already set unchanged.
- R10: The four flags (`suspend_flag`, `idle5_flag`, `usb_rst_flag`, `resume_flag`) are sticky. `fw_clr_flags` clears them all on the next edge, but a set condition present in the same cycle wins. `usb_rst_det` sets `usb_rst_flag`, and `resume_det` sets `resume_flag`.
- R11: `ep_disable` is high exactly while the state is reset. `port_hold` is high in every state except operational.
- R12: State codes are 2'b00 reset, 2'b01 resume, 2'b10 operational and 2'b11 suspend. Any command that does not apply to the current state leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous module reset, active low |
| bus_active | input | 1 | Upstream port activity seen this cycle |
| usb_rst_det | input | 1 | USB reset detected on the bus |
| resume_det | input | 1 | Resume signalling detected on the bus |
| fw_set_suspend | input | 1 | Firmware request to enter suspend |
| fw_set_oper | input | 1 | Firmware request to enter operational |
| fw_set_reset | input | 1 | Firmware request to enter reset |
| fw_clr_flags | input | 1 | Firmware clear of all sticky flags |
| local_wake | input | 1 | Local wake-up request |
| node_state | output | 2 | Current state code |
| ep_disable | output | 1 | All endpoint pipes disabled |
| port_hold | output | 1 | Port registers and internal logic held inactive |
| suspend_flag | output | 1 | Sticky suspend-detected flag |
| idle5_flag | output | 1 | Sticky long-idle flag that permits remote wake-up |
| usb_rst_flag | output | 1 | Sticky USB reset flag |
| resume_flag | output | 1 | Sticky resume-detected flag |

## Verification
Every state change and every flag update becomes visible one clock edge after the inputs that cause it. The bench therefore drives inputs at the falling edge and compares all outputs at the next falling edge against a model that updates on the rising edge in between. Flag timing depends on the exact number of idle edges since the last active cycle, so the model counts those edges itself. It derives the edge where each flag rises from SUSP_US*TICK_DIV and WAKE_US*TICK_DIV. `ep_disable` and `port_hold` follow the state with no delay and are compared in the same sample.

// File: rtl/usb_node_pwr_fsm.sv
module usb_node_pwr_fsm #(
  parameter int TICK_DIV = 48,
  parameter int SUSP_US  = 3000,
  parameter int WAKE_US  = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_active,
  input  logic       usb_rst_det,
  input  logic       resume_det,
  input  logic       fw_set_suspend,
  input  logic       fw_set_oper,
  input  logic       fw_set_reset,
  input  logic       fw_clr_flags,
  input  logic       local_wake,
  output logic [1:0] node_state,
  output logic       ep_disable,
  output logic       port_hold,
  output logic       suspend_flag,
  output logic       idle5_flag,
  output logic       usb_rst_flag,
  output logic       resume_flag
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int UW = $clog2(WAKE_US + 1);
  localparam logic [1:0] ST_RST = 2'b00, ST_RES = 2'b01, ST_OPR = 2'b10, ST_SUS = 2'b11;

  logic [1:0]    st, st_nx;
  logic [PW-1:0] pre;
  logic [UW-1:0] idle_us;

  wire tick     = (pre == PW'(TICK_DIV - 1));
  wire susp_hit = (idle_us >= UW'(SUSP_US));
  wire wake_hit = (idle_us == UW'(WAKE_US));
  wire go_reset = usb_rst_flag && fw_set_reset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre     <= '0;
      idle_us <= '0;
    end else if (bus_active) begin
      pre     <= '0;
      idle_us <= '0;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick && !wake_hit) idle_us <= idle_us + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      suspend_flag <= 1'b0;
      idle5_flag   <= 1'b0;
      usb_rst_flag <= 1'b0;
      resume_flag  <= 1'b0;
    end else begin
      suspend_flag <= (suspend_flag & ~fw_clr_flags) | susp_hit;
      idle5_flag   <= (idle5_flag   & ~fw_clr_flags) | wake_hit;
      usb_rst_flag <= (usb_rst_flag & ~fw_clr_flags) | usb_rst_det;
      resume_flag  <= (resume_flag  & ~fw_clr_flags) | resume_det;
    end
  end

  always_comb begin
    st_nx = st;
    if (go_reset) st_nx = ST_RST;
    else begin
      case (st)
        ST_RST: if (fw_set_oper) st_nx = ST_OPR;
        ST_OPR: if (suspend_flag && fw_set_suspend) st_nx = ST_SUS;
        ST_SUS: if (resume_flag || (local_wake && idle5_flag)) st_nx = ST_RES;
        default: if (resume_flag && fw_set_oper) st_nx = ST_OPR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_RST;
    else        st <= st_nx;
  end

  assign node_state = st;
  assign ep_disable = (st == ST_RST);
  assign port_hold  = (st != ST_OPR);

  assert_susp_confirm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (node_state == ST_OPR && !(suspend_flag && fw_set_suspend)) |=> node_state != ST_SUS);

  assert_oper_confirm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (node_state == ST_RES && !(resume_flag && fw_set_oper)) |=> node_state != ST_OPR);

  assert_wake_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (node_state == ST_SUS && !idle5_flag && !resume_flag) |=> node_state != ST_RES);

  assert_reset_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (usb_rst_flag && fw_set_reset) |=> node_state == ST_RST);

  assert_flags_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!fw_clr_flags && suspend_flag && idle5_flag) |=> (suspend_flag && idle5_flag));

  assert_idle_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle5_flag) |-> (suspend_flag || $past(suspend_flag) || $past(fw_clr_flags)));
endmodule

// File: tb/tb_usb_node_pwr_fsm.sv
module tb_usb_node_pwr_fsm;
  localparam int DIV = 3, SUS = 5, WAK = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_active = 1'b0, usb_rst_det = 1'b0, resume_det = 1'b0;
  logic fw_set_suspend = 1'b0, fw_set_oper = 1'b0, fw_set_reset = 1'b0;
  logic fw_clr_flags = 1'b0, local_wake = 1'b0;
  logic [1:0] node_state;
  logic ep_disable, port_hold, suspend_flag, idle5_flag, usb_rst_flag, resume_flag;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [1:0] e_st = 2'b00;
  logic e_sus = 0, e_wak = 0, e_rst = 0, e_res = 0;
  int k = 0;

  usb_node_pwr_fsm #(.TICK_DIV(DIV), .SUSP_US(SUS), .WAKE_US(WAK)) dut (
    .clk(clk), .rst_n(rst_n), .bus_active(bus_active), .usb_rst_det(usb_rst_det),
    .resume_det(resume_det), .fw_set_suspend(fw_set_suspend), .fw_set_oper(fw_set_oper),
    .fw_set_reset(fw_set_reset), .fw_clr_flags(fw_clr_flags), .local_wake(local_wake),
    .node_state(node_state), .ep_disable(ep_disable), .port_hold(port_hold),
    .suspend_flag(suspend_flag), .idle5_flag(idle5_flag), .usb_rst_flag(usb_rst_flag),
    .resume_flag(resume_flag));

  always #10 clk = ~clk;

  function automatic logic [1:0] next_st(input logic [1:0] s);
    if (e_rst && fw_set_reset) return 2'b00;
    case (s)
      2'b00: return fw_set_oper ? 2'b10 : s;
      2'b10: return (e_sus && fw_set_suspend) ? 2'b11 : s;
      2'b11: return (e_res || (local_wake && e_wak)) ? 2'b01 : s;
      default: return (e_res && fw_set_oper) ? 2'b10 : s;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      e_st = 2'b00; e_sus = 0; e_wak = 0; e_rst = 0; e_res = 0; k = 0;
    end else begin
      e_st  = next_st(e_st);
      e_sus = (e_sus & ~fw_clr_flags) | (k >= SUS * DIV);
      e_wak = (e_wak & ~fw_clr_flags) | (k >= WAK * DIV);
      e_rst = (e_rst & ~fw_clr_flags) | usb_rst_det;
      e_res = (e_res & ~fw_clr_flags) | resume_det;
      k = bus_active ? 0 : ((k < 100000) ? k + 1 : k);
    end
  end

  task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk("R2/R3/R4/R5/R6/R12 node_state", {2'b0, node_state}, {2'b0, e_st});
    chk("R7 suspend_flag", {3'b0, suspend_flag}, {3'b0, e_sus});
    chk("R8 idle5_flag", {3'b0, idle5_flag}, {3'b0, e_wak});
    chk("R9/R10 usb_rst_flag,resume_flag", {2'b0, usb_rst_flag, resume_flag}, {2'b0, e_rst, e_res});
    chk("R11 ep_disable,port_hold", {2'b0, ep_disable, port_hold},
        {2'b0, e_st == 2'b00, e_st != 2'b10});
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cmp_model();
  endtask

  task automatic idle_in();
    bus_active = 0; usb_rst_det = 0; resume_det = 0; fw_set_suspend = 0;
    fw_set_oper = 0; fw_set_reset = 0; fw_clr_flags = 0; local_wake = 0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired: got hang expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R1 state in reset", {2'b0, node_state}, 4'h0);
    chk("R1 flags in reset", {suspend_flag, idle5_flag, usb_rst_flag, resume_flag}, 4'h0);
    chk("R1 holds in reset", {2'b0, ep_disable, port_hold}, 4'h3);
    rst_n = 1'b1;
    step();
    chk("R1 after release", {2'b0, node_state, ep_disable, port_hold} , 4'h3);

    idle_in(); bus_active = 1; fw_set_reset = 1; step();
    chk("R6 reset cmd without flag ignored", {2'b0, node_state}, 4'h0);
    idle_in(); bus_active = 1; fw_set_oper = 1; step();
    chk("R5 reset to operational", {2'b0, node_state}, 4'h2);

    idle_in(); fw_set_suspend = 1; local_wake = 1;
    for (int i = 0; i < 20; i++) step();
    chk("R2 suspend after flag and confirm", {2'b0, node_state}, 4'h3);
    chk("R4 local wake ignored before long idle", {3'b0, idle5_flag}, 4'h0);
    for (int i = 0; i < 10; i++) step();
    chk("R4 local wake after long idle", {2'b0, node_state}, 4'h1);
    chk("R8 long idle flag set", {3'b0, idle5_flag}, 4'h1);

    idle_in(); bus_active = 1; fw_set_oper = 1; step();
    chk("R3 oper cmd without resume flag ignored", {2'b0, node_state}, 4'h1);
    idle_in(); bus_active = 1; resume_det = 1; step();
    idle_in(); bus_active = 1; fw_set_oper = 1; step();
    chk("R3 resume to operational", {2'b0, node_state}, 4'h2);

    idle_in(); bus_active = 1; fw_set_reset = 1; step();
    chk("R6 reset cmd alone ignored in operational", {2'b0, node_state}, 4'h2);
    idle_in(); bus_active = 1; usb_rst_det = 1; step();
    idle_in(); bus_active = 1; fw_set_reset = 1; fw_set_oper = 1; step();
    chk("R6 reset overrides", {2'b0, node_state, ep_disable, port_hold}, 4'h3);

    idle_in(); bus_active = 1; fw_clr_flags = 1; step();
    chk("R10 clear all flags", {suspend_flag, idle5_flag, usb_rst_flag, resume_flag}, 4'h0);
    idle_in(); fw_clr_flags = 1; resume_det = 1; step();
    chk("R10 set wins over clear", {3'b0, resume_flag}, 4'h1);

    for (int seg = 0; seg < 100; seg++) begin
      bit quiet = ($urandom % 2) == 0;
      for (int c = 0; c < 40; c++) begin
        bus_active     = quiet ? 1'b0 : (($urandom % 3) == 0);
        usb_rst_det    = ($urandom % 40) == 0;
        resume_det     = ($urandom % 25) == 0;
        fw_set_suspend = ($urandom % 6) == 0;
        fw_set_oper    = ($urandom % 8) == 0;
        fw_set_reset   = ($urandom % 16) == 0;
        fw_clr_flags   = ($urandom % 30) == 0;
        local_wake     = ($urandom % 5) == 0;
        step();
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule